// File: doc/BRIEF.md
# Write-Once Windowed Watchdog Timer

This block is a system watchdog. A down-counter is decremented once every `DIV` pulses of a slow-clock enable, and software must restart it before it underflows. Underflow raises a sticky status flag and, if enabled, requests a system reset for a fixed number of slow-clock pulses. The slow-clock enable comes from outside the block and is a single-cycle pulse synchronous to `clk`.

All configuration sits in one mode word: reload value, restart-window threshold, reset enable, freeze-in-debug and disable. After each reset the mode word can be written exactly once, and later writes are dropped. A restart is accepted only as a single control write that sets the restart bit and carries the key byte in bits 31:24. It must also arrive while the counter is at or below the window threshold. A threshold of all ones opens the window permanently. A keyed restart that arrives too early is refused, raises the window-error flag and, if reset is enabled, requests a reset.

Top module: `wdog_lockwin`

## Requirements
- R1: After reset the count reads all ones, the status reads zero, `rst_req` and `fault` are low, and the mode word reads its default: reload and window all ones, reset-enable (bit 28) set, freeze (bit 29) and disable (bit 30) clear.
- R2: While running, the count drops by exactly one per `DIV` slow-clock pulses.
- R3: Only the first mode write after reset is accepted, and it reloads the counter. Later mode writes leave both the mode readback and the count unchanged. The mode word holds reload at bits CNT_W-1:0 and window at bits 2*CNT_W-1:CNT_W.
- R4: With the disable bit set, the count stays frozen, and no reset request or status flag appears.
- R5: When a divided tick finds the count at zero, status bit 0 (underflow) is set and the counter reloads. `rst_req` rises only if reset-enable is set.
- R6: Once triggered, `rst_req` stays high through `RST_HOLD` slow-clock pulses and then falls.
- R7: With the freeze bit set, counting stops while `dbg_in` is high. With the freeze bit clear, `dbg_in` has no effect.
- R8: A control write (address 0) restarts the counter only if bit 0 is set and bits 31:24 equal `KEY`. Any other control write is ignored.
- R9: A keyed restart while the count is above a window below all ones is refused. It sets status bit 1 (window error) and raises `rst_req` if reset-enable is set. At or below the threshold, the restart reloads the counter.
- R10: Reading the status register (address 2) clears both sticky bits. Bit 2 of the status register reports that the mode word is locked.
- R11: If an accepted restart and an underflow tick fall in the same cycle, the restart wins: the counter reloads, and no underflow or reset results.
- R12: `fault` is high exactly while either sticky status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading status clears it) |
| bus_addr | input | 2 | 0 control, 1 mode, 2 status, 3 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| slow_tick | input | 1 | One-cycle slow-clock enable pulse |
| dbg_in | input | 1 | Debug-halt request |
| rst_req | output | 1 | Reset request pulse |
| fault | output | 1 | Underflow or window error pending |

## Verification
Two events can land in the same cycle: a keyed restart and the divided tick that would underflow the counter. The bench provokes this by ticking a zero count up to the last prescaler step. It then drives the restart write and the final slow-clock pulse together. The test passes if the count reads back the reload value, the underflow flag is clear and `rst_req` stays low.

// File: rtl/wdog_lockwin_pkg.sv
package wdog_lockwin_pkg;

   typedef enum logic [1:0] {
      ADDR_CTRL = 2'd0,
      ADDR_MODE = 2'd1,
      ADDR_STAT = 2'd2,
      ADDR_CNT  = 2'd3
   } wdog_addr_e;

   typedef struct packed {
      logic dis;
      logic dbg_halt;
      logic rst_en;
   } mode_flags_t;

   localparam int BIT_RST_EN  = 28;
   localparam int BIT_FREEZE  = 29;
   localparam int BIT_DISABLE = 30;
   localparam int KEY_LSB     = 24;
   localparam int KEY_W       = 8;

endpackage

// File: rtl/wdog_lockwin_regs.sv
module wdog_lockwin_regs
   import wdog_lockwin_pkg::*;
#(
   parameter int               CNT_W = 12,
   parameter logic [KEY_W-1:0] KEY   = 8'hA5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             uf_evt,
   input  logic             win_evt,
   output logic [31:0]      bus_rdata,
   output logic [CNT_W-1:0] reload_q,
   output logic [CNT_W-1:0] window_q,
   output logic [CNT_W-1:0] reload_nxt,
   output mode_flags_t      flags,
   output logic             mode_load,
   output logic             restart_req,
   output logic             fault
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic locked, sts_uf, sts_err, stat_rd;
   logic unused_wdata;

   assign mode_load   = bus_wr && (bus_addr == ADDR_MODE) && !locked;
   assign restart_req = bus_wr && (bus_addr == ADDR_CTRL) && bus_wdata[0]
                        && (bus_wdata[KEY_LSB +: KEY_W] == KEY);
   assign stat_rd     = bus_rd && (bus_addr == ADDR_STAT);
   assign reload_nxt  = mode_load ? bus_wdata[CNT_W-1:0] : reload_q;
   assign fault       = sts_uf | sts_err;
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked   <= 1'b0;
         reload_q <= ALL_ONES;
         window_q <= ALL_ONES;
         flags    <= '{dis: 1'b0, dbg_halt: 1'b0, rst_en: 1'b1};
         sts_uf   <= 1'b0;
         sts_err  <= 1'b0;
      end else begin
         if (mode_load) begin
            locked   <= 1'b1;
            reload_q <= bus_wdata[CNT_W-1:0];
            window_q <= bus_wdata[2*CNT_W-1:CNT_W];
            flags    <= '{dis:      bus_wdata[BIT_DISABLE],
                          dbg_halt: bus_wdata[BIT_FREEZE],
                          rst_en:   bus_wdata[BIT_RST_EN]};
         end
         sts_uf  <= uf_evt  | (sts_uf  & !stat_rd);
         sts_err <= win_evt | (sts_err & !stat_rd);
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_CTRL: bus_rdata = '0;
         ADDR_MODE: begin
            bus_rdata[CNT_W-1:0]       = reload_q;
            bus_rdata[2*CNT_W-1:CNT_W] = window_q;
            bus_rdata[BIT_RST_EN]      = flags.rst_en;
            bus_rdata[BIT_FREEZE]      = flags.dbg_halt;
            bus_rdata[BIT_DISABLE]     = flags.dis;
         end
         ADDR_STAT: bus_rdata[2:0] = {locked, sts_err, sts_uf};
         ADDR_CNT:  bus_rdata[CNT_W-1:0] = cnt;
         default:   bus_rdata = '0;
      endcase
   end

   // R3: once locked, a mode write changes nothing
   p_mode_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && bus_wr && bus_addr == ADDR_MODE) |=> $stable(reload_q) && $stable(window_q) && $stable(flags));
   // R5: underflow event leaves the sticky flag set
   p_uf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt |=> sts_uf);
   // R9: refused restart leaves the error flag set
   p_win_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      win_evt |=> sts_err);
   // R10: a status read with no new event clears the flags
   p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !uf_evt && !win_evt) |=> !fault);

endmodule

// File: rtl/wdog_lockwin_core.sv
module wdog_lockwin_core
   import wdog_lockwin_pkg::*;
#(
   parameter int CNT_W = 12,
   parameter int DIV   = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             dbg_in,
   input  logic [CNT_W-1:0] reload_q,
   input  logic [CNT_W-1:0] reload_nxt,
   input  logic [CNT_W-1:0] window_q,
   input  mode_flags_t      flags,
   input  logic             mode_load,
   input  logic             restart_req,
   output logic [CNT_W-1:0] cnt,
   output logic             uf_evt,
   output logic             win_evt
);

   logic run, step, div_tick, open_win, restart_ok, load;

   assign run        = !flags.dis && !(flags.dbg_halt && dbg_in);
   assign step       = slow_tick && run;
   assign open_win   = (&window_q) || (cnt <= window_q);
   assign restart_ok = restart_req && !flags.dis && open_win;
   assign win_evt    = restart_req && !flags.dis && !open_win;
   assign load       = restart_ok || mode_load;
   assign uf_evt     = div_tick && (cnt == '0) && !load;

   generate
      if (DIV == 1) begin : g_nodiv
         assign div_tick = step;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] PLAST = PW'(DIV - 1);
         logic [PW-1:0] presc;
         assign div_tick = step && (presc == PLAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        presc <= '0;
            else if (load)     presc <= '0;
            else if (div_tick) presc <= '0;
            else if (step)     presc <= presc + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= {CNT_W{1'b1}};
      else if (load)     cnt <= reload_nxt;
      else if (div_tick) cnt <= (cnt == '0) ? reload_q : cnt - 1'b1;
   end

   // R4: disabled counter never moves
   p_dis_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flags.dis |=> $stable(cnt));
   // R7: frozen in debug with no load
   p_dbg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.dbg_halt && dbg_in && !load) |=> $stable(cnt));
   // R11: a restart never coincides with an underflow event
   p_restart_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      restart_ok |-> !uf_evt);
   // R2: count only moves on a tick or a load
   p_step_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!slow_tick && !restart_req && !mode_load) |=> $stable(cnt));

endmodule

// File: rtl/wdog_lockwin_pulse.sv
module wdog_lockwin_pulse #(
   parameter int RST_HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic slow_tick,
   output logic rst_req
);

   localparam int HW = $clog2(RST_HOLD + 1);
   localparam logic [HW-1:0] HOLD_V = HW'(RST_HOLD);

   logic [HW-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        hold <= '0;
      else if (start)                    hold <= HOLD_V;
      else if (slow_tick && hold != '0)  hold <= hold - 1'b1;
   end

   assign rst_req = (hold != '0);

   // R6: the request only drops on a slow-clock pulse
   p_hold_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !slow_tick) |=> rst_req);
   // R6: a start always raises the request
   p_start_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> rst_req);

endmodule

// File: rtl/wdog_lockwin.sv
module wdog_lockwin
   import wdog_lockwin_pkg::*;
#(
   parameter int               CNT_W    = 12,
   parameter int               DIV      = 128,
   parameter int               RST_HOLD = 4,
   parameter logic [KEY_W-1:0] KEY      = 8'hA5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        slow_tick,
   input  logic        dbg_in,
   output logic        rst_req,
   output logic        fault
);

   generate
      if (CNT_W < 2 || 2 * CNT_W > BIT_RST_EN) begin : g_bad_w
         $error("CNT_W must lie in 2..14");
      end
      if (DIV < 1) begin : g_bad_div
         $error("DIV must be at least 1");
      end
      if (RST_HOLD < 1) begin : g_bad_hold
         $error("RST_HOLD must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, reload_q, reload_nxt, window_q;
   mode_flags_t      flags;
   logic             mode_load, restart_req, uf_evt, win_evt, start;

   wdog_lockwin_regs #(.CNT_W(CNT_W), .KEY(KEY)) u_regs (
      .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
      .cnt, .uf_evt, .win_evt, .bus_rdata, .reload_q, .window_q,
      .reload_nxt, .flags, .mode_load, .restart_req, .fault
   );

   wdog_lockwin_core #(.CNT_W(CNT_W), .DIV(DIV)) u_core (
      .clk, .rst_n, .slow_tick, .dbg_in, .reload_q, .reload_nxt,
      .window_q, .flags, .mode_load, .restart_req, .cnt, .uf_evt, .win_evt
   );

   assign start = flags.rst_en && (uf_evt || win_evt);

   wdog_lockwin_pulse #(.RST_HOLD(RST_HOLD)) u_pulse (
      .clk, .rst_n, .start, .slow_tick, .rst_req
   );

   // R5: no reset request starts while reset-enable is clear
   p_no_rst_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags.rst_en && !rst_req) |=> !rst_req);

endmodule

// File: tb/wdog_lockwin_tb.sv
module wdog_lockwin_tb;

   localparam int CW   = 6;
   localparam int DV   = 4;
   localparam int HOLD = 3;
   localparam logic [7:0] K = 8'hA5;
   localparam int ONES = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic slow_tick = 1'b0, dbg_in = 1'b0;
   logic rst_req, fault;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   wdog_lockwin #(.CNT_W(CW), .DIV(DV), .RST_HOLD(HOLD), .KEY(K)) u_dut (
      .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
      .slow_tick, .dbg_in, .rst_req, .fault
   );

   function automatic logic [31:0] mk_mode(int rel, int win, bit rsten, bit frz, bit dis);
      return (32'(dis) << 30) | (32'(frz) << 29) | (32'(rsten) << 28)
             | (32'(win) << CW) | 32'(rel);
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_wr = 0; bus_rd = 0; slow_tick = 0; dbg_in = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         slow_tick = 1'b1;
         @(negedge clk);
         slow_tick = 1'b0;
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      // R1 reset state
      do_reset();
      rd(2'd3, d); chk("R1 count", d, ONES);
      rd(2'd2, d); chk("R1 status", d, 0);
      rd(2'd1, d); chk("R1 mode", d, mk_mode(ONES, ONES, 1, 0, 0));
      chk("R1 rst_req", rst_req, 0);
      chk("R1 fault", fault, 0);

      // R2 sweep of reload values, one decrement per DV ticks
      for (int r = 1; r < ONES; r += 8) begin
         do_reset();
         wr(2'd1, mk_mode(r, ONES, 0, 0, 0));
         for (int k = 1; k <= r; k++) begin
            ticks(DV - 1);
            rd(2'd3, d); chk("R2 pre-step", d, r - k + 1);
            ticks(1);
            rd(2'd3, d); chk("R2 step", d, r - k);
         end
      end

      // R3 write-once
      do_reset();
      wr(2'd1, mk_mode(9, 20, 1, 0, 0));
      ticks(DV);
      wr(2'd1, mk_mode(30, 3, 0, 1, 1));
      rd(2'd1, d); chk("R3 mode kept", d, mk_mode(9, 20, 1, 0, 0));
      rd(2'd3, d); chk("R3 count kept", d, 8);
      rd(2'd2, d); chk("R10 locked bit", d, 4);

      // R4 disable
      do_reset();
      wr(2'd1, mk_mode(2, ONES, 1, 0, 1));
      ticks(DV * 5);
      rd(2'd3, d); chk("R4 count frozen", d, 2);
      chk("R4 no rst", rst_req, 0);
      rd(2'd2, d); chk("R4 no status", d, 4);

      // R5/R6 underflow with reset enabled
      do_reset();
      wr(2'd1, mk_mode(2, ONES, 1, 0, 0));
      ticks(DV * 3 - 1);
      chk("R5 no rst before", rst_req, 0);
      ticks(1);
      chk("R5 rst_req", rst_req, 1);
      chk("R12 fault set", fault, 1);
      rd(2'd3, d); chk("R5 reloaded", d, 2);
      ticks(HOLD - 1);
      chk("R6 still high", rst_req, 1);
      ticks(1);
      chk("R6 dropped", rst_req, 0);
      rd(2'd2, d); chk("R5 uf flag", d, 5);
      rd(2'd2, d); chk("R10 cleared", d, 4);
      chk("R12 fault clear", fault, 0);

      // R5 underflow without reset enable
      do_reset();
      wr(2'd1, mk_mode(1, ONES, 0, 0, 0));
      ticks(DV * 2);
      chk("R5 no rst when off", rst_req, 0);
      rd(2'd2, d); chk("R5 uf flag off", d, 5);

      // R7 debug freeze
      do_reset();
      wr(2'd1, mk_mode(10, ONES, 0, 1, 0));
      dbg_in = 1'b1;
      ticks(DV * 3);
      rd(2'd3, d); chk("R7 frozen", d, 10);
      dbg_in = 1'b0;
      ticks(DV);
      rd(2'd3, d); chk("R7 resumes", d, 9);
      do_reset();
      wr(2'd1, mk_mode(10, ONES, 0, 0, 0));
      dbg_in = 1'b1;
      ticks(DV * 2);
      dbg_in = 1'b0;
      rd(2'd3, d); chk("R7 no freeze bit", d, 8);

      // R8 key
      do_reset();
      wr(2'd1, mk_mode(12, ONES, 1, 0, 0));
      ticks(DV * 4);
      wr(2'd0, {8'h5A, 23'd0, 1'b1});
      rd(2'd3, d); chk("R8 bad key", d, 8);
      wr(2'd0, {K, 24'd0});
      rd(2'd3, d); chk("R8 no bit", d, 8);
      wr(2'd0, {K, 23'd0, 1'b1});
      rd(2'd3, d); chk("R8 good", d, 12);
      chk("R8 no rst", rst_req, 0);

      // R9 window
      do_reset();
      wr(2'd1, mk_mode(5, 1, 1, 0, 0));
      wr(2'd0, {K, 23'd0, 1'b1});
      chk("R9 early rst", rst_req, 1);
      rd(2'd3, d); chk("R9 early count", d, 5);
      rd(2'd2, d); chk("R9 err flag", d, 6);
      ticks(HOLD + DV * 4);
      rd(2'd3, d); chk("R9 in window count", d, 1);
      wr(2'd0, {K, 23'd0, 1'b1});
      rd(2'd3, d); chk("R9 accepted", d, 5);
      rd(2'd2, d); chk("R9 no err", d, 4);
      chk("R9 no rst", rst_req, 0);

      // R11 restart same cycle as underflow tick
      do_reset();
      wr(2'd1, mk_mode(2, ONES, 1, 0, 0));
      ticks(DV * 3 - 1);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = {K, 23'd0, 1'b1}; slow_tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; slow_tick = 1'b0;
      chk("R11 no rst", rst_req, 0);
      rd(2'd3, d); chk("R11 reloaded", d, 2);
      rd(2'd2, d); chk("R11 no uf", d, 4);

      finish_run();
   end

endmodule